// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Output Shifter

This block is a purely combinational datapath slice. It takes two operands, a carry input and a five-bit select, and returns one result word and a carry-out. An adder section and a bitwise section work side by side. Select bit 2 chooses which of the two results goes on. That value then passes through a one-position shift stage, which select bits 4 and 3 control.

The adder section always computes the operand A plus a second addend plus the carry input. Select bits 1:0 pick the second addend: zero, B, the bitwise inverse of B, or all ones. Because the carry input is part of the sum, one select code gives two related operations: pass and increment, add and add-with-carry, add-inverse and subtract, decrement and pass. The operand width is a parameter, with a default of 8. A second parameter chooses between an explicit ripple-carry chain and a plain behavioural adder.

The block has no clock and no reset. Both outputs follow the inputs within the same evaluation.

Top module: `alu8_core`

## Requirements
- R1: With sel[2]=0 and sel[1:0]=00, the pre-shift result is opa when carry_in=0 and opa+1 (modulo 2^WIDTH) when carry_in=1.
- R2: With sel[2]=0 and sel[1:0]=01, the pre-shift result is opa+opb+carry_in (modulo 2^WIDTH).
- R3: With sel[2]=0 and sel[1:0]=10, the pre-shift result is opa+(~opb)+carry_in. With carry_in=1 this equals opa-opb.
- R4: With sel[2]=0 and sel[1:0]=11, the pre-shift result is opa-1 when carry_in=0 and opa unchanged when carry_in=1.
- R5: While the adder section is selected (sel[2]=0), carry_out is bit WIDTH of the full sum opa + addend + carry_in. The addend is 0, opb, ~opb or all ones for sel[1:0] = 00, 01, 10, 11 respectively.
- R6: With sel[2]=1, the pre-shift result is opa AND opb for sel[1:0]=00, opa OR opb for 01, opa XOR opb for 10, and NOT opa for 11.
- R7: With sel[2]=1, carry_in has no effect on result or carry_out.
- R8: sel[4:3] sets the shift stage applied to the chosen value:
  - 00 passes the value unchanged.
  - 01 shifts it left by one, filling bit 0 with 0.
  - 10 shifts it right by one, filling the top bit with 0.
  - 11 forces result to all zeros.
  - The bit shifted out is discarded.
- R9: carry_out is 0 whenever sel[2]=1. The shift stage never changes carry_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry added into the adder section |
| sel | input | 5 | Operation select: [1:0] operation, [2] adder/bitwise choice, [4:3] shift mode |
| result | output | WIDTH | Shifted result |
| carry_out | output | 1 | Carry from the adder section, 0 for bitwise operations |

## Verification
The bench builds the block with the defaults: WIDTH of 8 and the ripple-carry adder variant. At 8 bits, all 64 combinations of select and carry input are cheap to sweep for every operand pair. The sweep covers the carry-chain corners that matter: all-ones plus one, zero minus one, equal operands under subtraction, and alternating bit patterns. Running the ripple variant exercises the generated per-bit carry chain. The behavioural adder reaches the same sums with less exposed structure.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   // Width of the select bus; the field positions below depend on it.
   localparam int SEL_W = 5;

   // Adder-section codes on sel[1:0]: which addend joins opa.
   localparam logic [1:0] AR_ZERO  = 2'b00;
   localparam logic [1:0] AR_OPB   = 2'b01;
   localparam logic [1:0] AR_NOTB  = 2'b10;
   localparam logic [1:0] AR_ONES  = 2'b11;

   // Bitwise-section codes on sel[1:0].
   localparam logic [1:0] LG_AND   = 2'b00;
   localparam logic [1:0] LG_OR    = 2'b01;
   localparam logic [1:0] LG_XOR   = 2'b10;
   localparam logic [1:0] LG_NOTA  = 2'b11;

   // Shift-stage codes on sel[4:3].
   typedef enum logic [1:0] {
      SH_PASS  = 2'b00,
      SH_LEFT  = 2'b01,
      SH_RIGHT = 2'b10,
      SH_CLEAR = 2'b11
   } shift_mode_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [1:0]       op,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int SUM_W = WIDTH + 1;

   logic [WIDTH-1:0] addend;

   always_comb begin
      case (op)
         AR_ZERO: addend = '0;
         AR_OPB:  addend = opb;
         AR_NOTB: addend = ~opb;
         default: addend = '1;
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = opa[i] ^ addend[i] ^ carry[i];
            assign carry[i+1] = (opa[i] & addend[i]) | (carry[i] & (opa[i] ^ addend[i]));
         end
         assign cout = carry[WIDTH];
      end else begin : g_behav
         logic [SUM_W-1:0] wide;
         assign wide = {1'b0, opa} + {1'b0, addend} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   // R3: equal operands under subtraction give zero with carry set
   always_comb begin
      if (op == AR_NOTB && cin && opa == opb)
         a_r3_sub_equal_zero: assert (sum == '0 && cout) else $error("R3 subtract of equal operands not zero");
   end

   // R4: decrement of zero wraps to all ones with no carry
   always_comb begin
      if (op == AR_ONES && !cin && opa == '0)
         a_r4_dec_wrap: assert (sum == '1 && !cout) else $error("R4 decrement of zero did not wrap");
   end

   // R5: a pass-through code cannot produce a carry
   always_comb begin
      if (op == AR_ZERO && !cin)
         a_r5_pass_no_carry: assert (!cout && sum == opa) else $error("R5 pass code produced carry");
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [1:0]       op,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      case (op)
         LG_AND:  res = opa & opb;
         LG_OR:   res = opa | opb;
         LG_XOR:  res = opa ^ opb;
         default: res = ~opa;
      endcase
   end

   // R6: an AND result never sets a bit that opa lacks
   always_comb begin
      if (op == LG_AND)
         a_r6_and_subset: assert ((res & ~opa) == '0) else $error("R6 AND set bit outside opa");
   end

   // R6: OR result always covers opb
   always_comb begin
      if (op == LG_OR)
         a_r6_or_cover: assert ((opb & ~res) == '0) else $error("R6 OR lost bit of opb");
   end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] din,
   input  logic [1:0]       mode,
   output logic [WIDTH-1:0] dout
);
   localparam int TOP = WIDTH - 1;

   shift_mode_e mode_e;
   assign mode_e = shift_mode_e'(mode);

   always_comb begin
      case (mode_e)
         SH_PASS:  dout = din;
         SH_LEFT:  dout = {din[TOP-1:0], 1'b0};
         SH_RIGHT: dout = {1'b0, din[TOP:1]};
         default:  dout = '0;
      endcase
   end

   // R8: left shift vacates bit 0 and keeps the next-lower bit in place above it
   always_comb begin
      if (mode_e == SH_LEFT)
         a_r8_left_fill: assert (!dout[0] && dout[1] == din[0]) else $error("R8 left shift fill wrong");
   end

   // R8: right shift vacates the top bit
   always_comb begin
      if (mode_e == SH_RIGHT)
         a_r8_right_fill: assert (!dout[TOP] && dout[0] == din[1]) else $error("R8 right shift fill wrong");
   end

   // R8: clear mode has no set bit
   always_comb begin
      if (mode_e == SH_CLEAR)
         a_r8_clear: assert ($countones(dout) == 0) else $error("R8 clear mode left bits set");
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             carry_in,
   input  logic [4:0]       sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   localparam int OP_LO    = 0;
   localparam int PICK_BIT = 2;
   localparam int SH_LO    = 3;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu8_core: WIDTH must be at least 2");
      end
      if (SEL_W != 5) begin : g_bad_sel
         $error("alu8_core: select field layout expects five bits");
      end
   endgenerate

   logic [WIDTH-1:0] arith_sum;
   logic             arith_cout;
   logic [WIDTH-1:0] logic_res;
   logic [WIDTH-1:0] chosen;
   logic             pick_logic;

   assign pick_logic = sel[PICK_BIT];

   alu8_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .opa  (opa),
      .opb  (opb),
      .op   (sel[OP_LO+1:OP_LO]),
      .cin  (carry_in),
      .sum  (arith_sum),
      .cout (arith_cout)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .opa (opa),
      .opb (opb),
      .op  (sel[OP_LO+1:OP_LO]),
      .res (logic_res)
   );

   assign chosen = pick_logic ? logic_res : arith_sum;

   alu8_shifter #(.WIDTH(WIDTH)) u_shift (
      .din  (chosen),
      .mode (sel[SH_LO+1:SH_LO]),
      .dout (result)
   );

   assign carry_out = pick_logic ? 1'b0 : arith_cout;

   // R9: bitwise operations never report a carry
   always_comb begin
      if (pick_logic)
         a_r9_logic_no_carry: assert (!carry_out) else $error("R9 carry set for bitwise op");
   end

   // R8: pass mode forwards the section output untouched
   always_comb begin
      if (sel[SH_LO+1:SH_LO] == SH_PASS)
         a_r8_pass_through: assert (result == (pick_logic ? logic_res : arith_sum))
            else $error("R8 pass mode altered value");
   end
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic         carry_in = 1'b0;
   logic [4:0]   sel = '0;
   logic [W-1:0] result;
   logic         carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   alu8_core #(.WIDTH(W), .RIPPLE(1'b1)) i_alu8_core (
      .opa       (opa),
      .opb       (opb),
      .carry_in  (carry_in),
      .sel       (sel),
      .result    (result),
      .carry_out (carry_out)
   );

   // Reference: returns {carry, result} from the requirement text.
   function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic [4:0] s);
      int unsigned full;
      logic [7:0]  pre;
      logic        co;
      if (!s[2]) begin
         case (s[1:0])
            2'b00: full = a + c;                 // R1
            2'b01: full = a + b + c;             // R2
            2'b10: full = a + (255 - b) + c;     // R3
            default: full = a + 255 + c;         // R4
         endcase
         pre = full[7:0];
         co  = full[8];                          // R5
      end else begin
         case (s[1:0])
            2'b00: pre = a & b;                  // R6
            2'b01: pre = a | b;
            2'b10: pre = a ^ b;
            default: pre = ~a;
         endcase
         co = 1'b0;                              // R9
      end
      case (s[4:3])
         2'b00: model = {co, pre};               // R8
         2'b01: model = {co, pre[6:0], 1'b0};
         2'b10: model = {co, 1'b0, pre[7:1]};
         default: model = {co, 8'h00};
      endcase
   endfunction

   function automatic string res_tag(input logic c, input logic [4:0] s);
      if (s[4:3] != 2'b00) return "R8";
      if (s[2]) return c ? "R7" : "R6";
      case (s[1:0])
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic apply(input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic [4:0] s);
      logic [8:0] exp;
      string      rt;
      string      ct;
      @(negedge clk);
      opa = a; opb = b; carry_in = c; sel = s;
      #2;
      exp = model(a, b, c, s);
      rt  = res_tag(c, s);
      ct  = (s[2] || s[4:3] != 2'b00) ? "R9" : "R5";
      checks++;
      if (result !== exp[7:0]) begin
         errors++;
         $display("FAIL %s result a=%h b=%h cin=%b sel=%b actual=%h expected=%h",
                  rt, a, b, c, s, result, exp[7:0]);
      end
      checks++;
      if (carry_out !== exp[8]) begin
         errors++;
         $display("FAIL %s carry a=%h b=%h cin=%b sel=%b actual=%b expected=%b",
                  ct, a, b, c, s, carry_out, exp[8]);
      end
   endtask

   initial begin
      logic [7:0] corner [7];
      corner[0] = 8'h00; corner[1] = 8'hFF; corner[2] = 8'h01; corner[3] = 8'h80;
      corner[4] = 8'h7F; corner[5] = 8'h55; corner[6] = 8'hAA;
      void'($urandom(32'd1234));

      // Idle state with zero inputs: R1 pass of zero, no carry
      @(negedge clk); #2;
      checks++;
      if (result !== 8'h00 || carry_out !== 1'b0) begin
         errors++;
         $display("FAIL R1 idle actual=%h/%b expected=00/0", result, carry_out);
      end

      // Directed corners
      apply(8'hFF, 8'h00, 1'b1, 5'b00000);   // R1 / R5: increment wraps, carry 1
      apply(8'h3C, 8'h3C, 1'b1, 5'b00010);   // R3 equal subtract -> 0, carry 1
      apply(8'h00, 8'h00, 1'b0, 5'b00011);   // R4 decrement zero -> FF, carry 0
      apply(8'h42, 8'h99, 1'b1, 5'b00011);   // R4 pass with cin
      apply(8'hF0, 8'h0F, 1'b0, 5'b10001);   // R8 right after add, R9 carry kept
      apply(8'h81, 8'h00, 1'b0, 5'b01000);   // R8 left drops top bit
      apply(8'hFF, 8'h01, 1'b1, 5'b11001);   // R8 clear, R9 carry survives clear
      apply(8'hA5, 8'h5A, 1'b1, 5'b00110);   // R7 XOR ignores cin

      // Sweep every select and carry combination
      for (int s = 0; s < 32; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 7; i++)
               for (int j = 0; j < 7; j++)
                  apply(corner[i], corner[j], c[0], s[4:0]);
            for (int k = 0; k < 20; k++)
               apply(8'($urandom), 8'($urandom), c[0], s[4:0]);
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule